// File: doc/BRIEF.md
# Translated Direct-Mapped Data Cache

This block sits on the data-access path of a small processor. The CPU presents a virtual byte address together with a read or write request. An eight-entry, fully associative translation buffer maps the 20-bit virtual page number to a physical page number. Pages are 4 KB, so the low 12 address bits pass through unchanged. The physical address then indexes a 1024-entry direct-mapped cache. Each cache line holds exactly one 32-bit word.

A read hit completes in the cycle it is presented. A read miss stalls the CPU and requests the word from memory over a fill port whose latency is variable. When the word arrives, the block installs it in its line and retries the read, which then hits. Writes are write-through and always allocate. A permitted write updates the indexed line and pushes the physical address and data into an external write buffer, and it waits while that buffer reports full. A translation miss or a write to a read-only page ends the access at once with an exception flag and changes nothing.

The control is a two-state machine:
- `ST_LOOKUP`: translation, tag compare, hits, writes and exceptions are all handled here.
- `ST_FILL`: the block waits for the memory word.

The transitions are:
- `ST_LOOKUP`→`ST_FILL` on a read that translates but misses in the cache (the miss transition).
- `ST_FILL`→`ST_LOOKUP` when the fill data is valid (the install-and-retry transition).
- `ST_LOOKUP`→`ST_LOOKUP` for every other outcome.

Top module: `xdc_cache`

## Requirements
- R1: A synchronous reset clears every translation-buffer and cache valid bit. After reset, any access raises a translation miss until an entry is loaded, and the first read of any translated address misses in the cache.
- R2: An access whose virtual page (bits 31..12) matches no valid translation entry completes with `cpu_ready` and `exc_tlb_miss` high in the same cycle. It neither requests a fill nor pushes to the write buffer.
- R3: The physical address is the entry's physical page number in bits 31..12 followed by virtual address bits 11..0. It appears as `wb_addr` on a write and word-aligned (bits 1..0 zero) as `fill_addr` on a read miss.
- R4: A read hits only when the line selected by physical bits 11..2 is valid and its stored tag equals physical bits 31..12. Two addresses with equal bits 11..2 and different tags evict each other.
- R5: A write that hits a translation entry whose write-permission bit is clear completes at once with `exc_wprot` high. It makes no push and leaves the cached word unchanged.
- R6: A permitted write pushes the physical address and data (`wb_push` high for one cycle, together with `cpu_ready`). It also writes the word and tag into the indexed line and marks the line valid, so a later read of that address hits and returns the written data.
- R7: While `wb_full` is high, a permitted write holds `cpu_ready` and `wb_push` low and does not change the cache. It completes in the first cycle in which `wb_full` is low.
- R8: On a read miss, `cpu_ready` stays low and `fill_req` rises in the next cycle. The fill word is installed on the cycle `fill_valid` is high, and the retried read completes one cycle later with that word. The total is latency+2 cycles after the request, where latency is the number of `fill_req` cycles before `fill_valid`.
- R9: A read hit completes with `cpu_ready` high and the cached word on `cpu_rdata` in the same cycle as the request, with no fill request.
- R10: Loading an entry writes it at a round-robin pointer that starts at 0 after reset and advances by one per load, wrapping after entry 7. A ninth load therefore replaces the first entry loaded. When several valid entries match, the lowest-numbered one is used.
- R11: Once raised, `fill_req` and `fill_addr` hold steady until `fill_valid` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_vaddr | input | 32 | Virtual byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Access complete this cycle |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` on a read |
| exc_tlb_miss | output | 1 | Translation miss, with `cpu_ready` |
| exc_wprot | output | 1 | Write to read-only page, with `cpu_ready` |
| fill_req | output | 1 | Memory fill request |
| fill_addr | output | 32 | Word-aligned physical fill address |
| fill_valid | input | 1 | Fill data valid |
| fill_data | input | 32 | Fill data word |
| wb_push | output | 1 | Write-buffer push |
| wb_addr | output | 32 | Physical write address |
| wb_data | output | 32 | Write data to buffer |
| wb_full | input | 1 | Write buffer cannot accept |
| tlb_ld | input | 1 | Load one translation entry |
| tlb_ld_vpn | input | 20 | Virtual page number to load |
| tlb_ld_ppn | input | 20 | Physical page number to load |
| tlb_ld_wr | input | 1 | Write-permission bit to load |

## Verification
The assertions assume that the CPU holds `cpu_req`, `cpu_we`, `cpu_vaddr` and `cpu_wdata` steady from the request until `cpu_ready`. They also assume that `fill_valid` is raised only while `fill_req` is high and that no entry is loaded while a fill is pending. The stimulus honours all three: it drives each access from one task that changes inputs only at falling edges after completion, it answers a fill only after sampling `fill_req`, and it loads entries only between accesses. Loaded virtual page numbers are kept distinct, except where the round-robin replacement is exercised deliberately. The sweep visits every mapped page at several offsets that collide on the same cache index, so eviction, write-permission and write-buffer back-pressure cases occur with varied fill latencies.

// File: rtl/xdc_pkg.sv
package xdc_pkg;
    typedef enum logic [0:0] {
        ST_LOOKUP = 1'b0,
        ST_FILL   = 1'b1
    } xdc_state_t;
endpackage

// File: rtl/xdc_tlb.sv
module xdc_tlb #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic [VPN_W-1:0] ld_vpn,
    input  logic [PPN_W-1:0] ld_ppn,
    input  logic             ld_wr,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output logic             lk_wr
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] ent_v;
    logic [VPN_W-1:0]   ent_vpn [ENTRIES];
    logic [PPN_W-1:0]   ent_ppn [ENTRIES];
    logic [ENTRIES-1:0] ent_wr;
    logic [PTR_W-1:0]   rr_ptr;
    logic [ENTRIES-1:0] match;

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_v  <= '0;
            rr_ptr <= '0;
        end else if (ld) begin
            ent_v[rr_ptr]   <= 1'b1;
            ent_vpn[rr_ptr] <= ld_vpn;
            ent_ppn[rr_ptr] <= ld_ppn;
            ent_wr[rr_ptr]  <= ld_wr;
            rr_ptr <= (rr_ptr == PTR_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = ent_v[g] && (ent_vpn[g] == lk_vpn);
    end

    // lowest-numbered matching entry wins
    always_comb begin
        lk_hit = 1'b0;
        lk_ppn = '0;
        lk_wr  = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                lk_hit = 1'b1;
                lk_ppn = ent_ppn[i];
                lk_wr  = ent_wr[i];
            end
        end
    end
endmodule

// File: rtl/xdc_line_store.sv
module xdc_line_store #(
    parameter int IDX_W  = 10,
    parameter int TAG_W  = 20,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0]  line_v;
    logic [TAG_W-1:0]  line_tag  [DEPTH];
    logic [DATA_W-1:0] line_word [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            line_v <= '0;
        end else if (wr_en) begin
            line_v[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_tag[wr_idx]  <= wr_tag;
            line_word[wr_idx] <= wr_data;
        end
    end

    assign rd_valid = line_v[rd_idx];
    assign rd_tag   = line_tag[rd_idx];
    assign rd_data  = line_word[rd_idx];
endmodule

// File: rtl/xdc_ctrl.sv
module xdc_ctrl
    import xdc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cpu_req,
    input  logic cpu_we,
    input  logic xl_hit,
    input  logic xl_wr_ok,
    input  logic line_hit,
    input  logic wb_full,
    input  logic fill_valid,
    output logic cpu_ready,
    output logic exc_tlb_miss,
    output logic exc_wprot,
    output logic wb_push,
    output logic fill_req,
    output logic fill_start,
    output logic line_wr,
    output logic line_from_fill
);
    xdc_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_LOOKUP;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d        = state_q;
        cpu_ready      = 1'b0;
        exc_tlb_miss   = 1'b0;
        exc_wprot      = 1'b0;
        wb_push        = 1'b0;
        fill_req       = 1'b0;
        fill_start     = 1'b0;
        line_wr        = 1'b0;
        line_from_fill = 1'b0;
        unique case (state_q)
            ST_LOOKUP: begin
                if (cpu_req) begin
                    if (!xl_hit) begin
                        cpu_ready    = 1'b1;
                        exc_tlb_miss = 1'b1;
                    end else if (cpu_we && !xl_wr_ok) begin
                        cpu_ready = 1'b1;
                        exc_wprot = 1'b1;
                    end else if (cpu_we) begin
                        if (!wb_full) begin
                            cpu_ready = 1'b1;
                            wb_push   = 1'b1;
                            line_wr   = 1'b1;
                        end
                    end else if (line_hit) begin
                        cpu_ready = 1'b1;
                    end else begin
                        fill_start = 1'b1;
                        state_d    = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                fill_req = 1'b1;
                if (fill_valid) begin
                    line_wr        = 1'b1;
                    line_from_fill = 1'b1;
                    state_d        = ST_LOOKUP;
                end
            end
            default: state_d = ST_LOOKUP;
        endcase
    end
endmodule

// File: rtl/xdc_cache.sv
module xdc_cache #(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int PAGE_W   = 12,
    parameter int IDX_W    = 10,
    parameter int TLB_ENTS = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cpu_req,
    input  logic                     cpu_we,
    input  logic [ADDR_W-1:0]        cpu_vaddr,
    input  logic [DATA_W-1:0]        cpu_wdata,
    output logic                     cpu_ready,
    output logic [DATA_W-1:0]        cpu_rdata,
    output logic                     exc_tlb_miss,
    output logic                     exc_wprot,
    output logic                     fill_req,
    output logic [ADDR_W-1:0]        fill_addr,
    input  logic                     fill_valid,
    input  logic [DATA_W-1:0]        fill_data,
    output logic                     wb_push,
    output logic [ADDR_W-1:0]        wb_addr,
    output logic [DATA_W-1:0]        wb_data,
    input  logic                     wb_full,
    input  logic                     tlb_ld,
    input  logic [ADDR_W-PAGE_W-1:0] tlb_ld_vpn,
    input  logic [ADDR_W-PAGE_W-1:0] tlb_ld_ppn,
    input  logic                     tlb_ld_wr
);
    localparam int PN_W  = ADDR_W - PAGE_W;
    localparam int OFF_W = $clog2(DATA_W / 8);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic              xl_hit, xl_wr_ok;
    logic [PN_W-1:0]   xl_ppn;
    logic [ADDR_W-1:0] paddr;
    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic              line_hit;
    logic              fill_start, line_wr, line_from_fill;
    logic [ADDR_W-1:0] fill_addr_q;
    logic [IDX_W-1:0]  wr_idx;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] wr_word;

    xdc_tlb #(.ENTRIES(TLB_ENTS), .VPN_W(PN_W), .PPN_W(PN_W)) u_tlb (
        .clk    (clk),
        .rst    (rst),
        .ld     (tlb_ld),
        .ld_vpn (tlb_ld_vpn),
        .ld_ppn (tlb_ld_ppn),
        .ld_wr  (tlb_ld_wr),
        .lk_vpn (cpu_vaddr[ADDR_W-1:PAGE_W]),
        .lk_hit (xl_hit),
        .lk_ppn (xl_ppn),
        .lk_wr  (xl_wr_ok)
    );

    assign paddr    = {xl_ppn, cpu_vaddr[PAGE_W-1:0]};
    assign line_hit = rd_valid && (rd_tag == paddr[ADDR_W-1:ADDR_W-TAG_W]);

    assign wr_idx  = line_from_fill ? fill_addr_q[OFF_W +: IDX_W] : paddr[OFF_W +: IDX_W];
    assign wr_tag  = line_from_fill ? fill_addr_q[ADDR_W-1:ADDR_W-TAG_W]
                                    : paddr[ADDR_W-1:ADDR_W-TAG_W];
    assign wr_word = line_from_fill ? fill_data : cpu_wdata;

    xdc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (paddr[OFF_W +: IDX_W]),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_data  (cpu_rdata),
        .wr_en    (line_wr),
        .wr_idx   (wr_idx),
        .wr_tag   (wr_tag),
        .wr_data  (wr_word)
    );

    xdc_ctrl u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .cpu_req        (cpu_req),
        .cpu_we         (cpu_we),
        .xl_hit         (xl_hit),
        .xl_wr_ok       (xl_wr_ok),
        .line_hit       (line_hit),
        .wb_full        (wb_full),
        .fill_valid     (fill_valid),
        .cpu_ready      (cpu_ready),
        .exc_tlb_miss   (exc_tlb_miss),
        .exc_wprot      (exc_wprot),
        .wb_push        (wb_push),
        .fill_req       (fill_req),
        .fill_start     (fill_start),
        .line_wr        (line_wr),
        .line_from_fill (line_from_fill)
    );

    // capture the word-aligned miss address so the fill is immune to input changes
    always_ff @(posedge clk) begin
        if (rst)             fill_addr_q <= '0;
        else if (fill_start) fill_addr_q <= {paddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end

    assign fill_addr = fill_addr_q;
    assign wb_addr   = paddr;
    assign wb_data   = cpu_wdata;
endmodule

// File: rtl/xdc_cache_chk.sv
module xdc_cache_chk (
    input logic        clk,
    input logic        rst,
    input logic        cpu_we,
    input logic [31:0] cpu_vaddr,
    input logic        cpu_ready,
    input logic        exc_tlb_miss,
    input logic        exc_wprot,
    input logic        fill_req,
    input logic [31:0] fill_addr,
    input logic        fill_valid,
    input logic        wb_push,
    input logic [31:0] wb_addr,
    input logic        wb_full
);
    assert_one_exception_R5: assert property (@(posedge clk) disable iff (rst)
        !(exc_tlb_miss && exc_wprot));

    assert_tlbmiss_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        exc_tlb_miss |-> (cpu_ready && !wb_push && !fill_req));

    assert_wprot_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        exc_wprot |-> (cpu_ready && !wb_push));

    assert_push_offset_R3: assert property (@(posedge clk) disable iff (rst)
        wb_push |-> (wb_addr[11:0] == cpu_vaddr[11:0]));

    assert_push_needs_space_R7: assert property (@(posedge clk) disable iff (rst)
        wb_push |-> (!wb_full && cpu_ready && cpu_we));

    assert_fill_stalls_R8: assert property (@(posedge clk) disable iff (rst)
        fill_req |-> (!cpu_ready && fill_addr[1:0] == 2'b00));

    assert_fill_holds_R11: assert property (@(posedge clk) disable iff (rst)
        (fill_req && !fill_valid) |=> (fill_req && $stable(fill_addr)));
endmodule

bind xdc_cache xdc_cache_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cpu_we       (cpu_we),
    .cpu_vaddr    (cpu_vaddr),
    .cpu_ready    (cpu_ready),
    .exc_tlb_miss (exc_tlb_miss),
    .exc_wprot    (exc_wprot),
    .fill_req     (fill_req),
    .fill_addr    (fill_addr),
    .fill_valid   (fill_valid),
    .wb_push      (wb_push),
    .wb_addr      (wb_addr),
    .wb_full      (wb_full)
);

// File: tb/tb_xdc_cache.sv
`timescale 1ns/1ps
module tb_xdc_cache;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_vaddr = '0, cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        exc_tlb_miss, exc_wprot;
    logic        fill_req;
    logic [31:0] fill_addr;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_data = '0;
    logic        wb_push;
    logic [31:0] wb_addr, wb_data;
    logic        wb_full = 1'b0;
    logic        tlb_ld = 1'b0;
    logic [19:0] tlb_ld_vpn = '0, tlb_ld_ppn = '0;
    logic        tlb_ld_wr = 1'b0;

    always #2 clk = ~clk;

    xdc_cache dut (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state built from the requirements
    logic        m_tv  [8];
    logic [19:0] m_vpn [8];
    logic [19:0] m_ppn [8];
    logic        m_wr  [8];
    int          m_ptr = 0;
    logic        c_v   [1024];
    logic [19:0] c_tag [1024];
    logic [31:0] c_dat [1024];
    logic [31:0] wmem  [logic [31:0]];

    task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        if (wmem.exists(a)) return wmem[a];
        return (a * 32'h9E37_79B1) ^ 32'h0000_C0DE;
    endfunction

    task automatic load_tlb(input logic [19:0] vpn, input logic [19:0] ppn, input logic wr);
        @(negedge clk);
        tlb_ld = 1'b1; tlb_ld_vpn = vpn; tlb_ld_ppn = ppn; tlb_ld_wr = wr;
        @(negedge clk);
        tlb_ld = 1'b0;
        m_tv[m_ptr] = 1'b1; m_vpn[m_ptr] = vpn; m_ppn[m_ptr] = ppn; m_wr[m_ptr] = wr;
        m_ptr = (m_ptr + 1) % 8;
    endtask

    task automatic access(input logic we, input logic [31:0] va, input logic [31:0] wd,
                          input int lat, input int fulln);
        logic        th = 0, tw = 0;
        logic [19:0] tp = '0;
        logic [31:0] pa, fa_exp, rd_exp;
        logic [9:0]  idx;
        logic        e_tlb, e_wp, e_push, e_fill;
        int          e_wait;
        int          cyc = 0, fc = 0;
        logic        g_tlb = 0, g_wp = 0, g_push = 0, g_fill = 0, early_push = 0;
        logic [31:0] g_rd = '0, g_wa = '0, g_wd = '0, g_fa = '0;
        for (int i = 7; i >= 0; i--)
            if (m_tv[i] && m_vpn[i] == va[31:12]) begin th = 1; tp = m_ppn[i]; tw = m_wr[i]; end
        pa = {tp, va[11:0]};
        idx = pa[11:2];
        fa_exp = {pa[31:2], 2'b00};
        e_tlb = !th; e_wp = th && we && !tw; e_push = th && we && tw;
        e_fill = th && !we && !(c_v[idx] && c_tag[idx] == pa[31:12]);
        rd_exp = e_fill ? mem_word(fa_exp) : c_dat[idx];
        e_wait = e_push ? fulln : (e_fill ? lat + 2 : 0);

        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_vaddr = va; cpu_wdata = wd;
        wb_full = (fulln > 0);
        forever begin
            #1;
            if (cpu_ready) begin
                g_tlb = exc_tlb_miss; g_wp = exc_wprot; g_push = wb_push;
                g_wa = wb_addr; g_wd = wb_data; g_rd = cpu_rdata;
                break;
            end
            if (wb_push) early_push = 1;
            if (fill_req) begin
                g_fill = 1; g_fa = fill_addr;
                if (fc == lat) begin fill_valid = 1; fill_data = mem_word(fill_addr); end
                else fc++;
            end
            @(negedge clk);
            fill_valid = 0;
            cyc++;
            wb_full = (cyc < fulln);
            if (cyc > 500) begin check("R8 hung access", 32'(cyc), 32'(e_wait)); break; end
        end
        @(negedge clk);
        cpu_req = 0; wb_full = 0;

        check("R2 translation-miss flag", 32'(g_tlb), 32'(e_tlb));
        check("R5 write-protect flag", 32'(g_wp), 32'(e_wp));
        check("R6 push at completion", 32'(g_push), 32'(e_push));
        check("R7 no push while full", 32'(early_push), 32'h0);
        check("R8 fill requested", 32'(g_fill), 32'(e_fill));
        check("R8 R9 cycles to ready", 32'(cyc), 32'(e_wait));
        if (e_push) begin
            check("R3 write address", g_wa, pa);
            check("R6 write data", g_wd, wd);
            c_v[idx] = 1; c_tag[idx] = pa[31:12]; c_dat[idx] = wd;
            wmem[fa_exp] = wd;
        end
        if (th && !we) check("R4 R9 read data", g_rd, rd_exp);
        if (e_fill) begin
            check("R3 R8 fill address", g_fa, fa_exp);
            c_v[idx] = 1; c_tag[idx] = pa[31:12]; c_dat[idx] = rd_exp;
        end
    endtask

    function automatic logic [19:0] vpn_of(input int p);
        return 20'h10000 + 20'(p * 3);
    endfunction

    initial begin
        logic [11:0] offs [5];
        offs[0] = 12'h000; offs[1] = 12'h004; offs[2] = 12'hFFC;
        offs[3] = 12'h7F3; offs[4] = 12'h400;
        for (int i = 0; i < 8; i++) m_tv[i] = 0;
        for (int i = 0; i < 1024; i++) c_v[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: empty translation buffer after reset
        access(0, 32'h1000_0040, '0, 0, 0);
        access(1, 32'h1000_0040, 32'h1234_5678, 0, 0);
        for (int p = 0; p < 8; p++)
            load_tlb(vpn_of(p), 20'h40000 + 20'(p * 20'h111), (p % 3) != 1);
        // R1: first read after reset misses
        access(0, {vpn_of(0), 12'h000}, '0, 1, 0);
        for (int p = 0; p < 9; p++) begin
            for (int o = 0; o < 5; o++) begin
                logic [31:0] va;
                va = {(p == 8) ? 20'h7FFFF : vpn_of(p), offs[o]};
                access(0, va, '0, (p + o) % 4, 0);
                access(0, va, '0, 0, 0);
                access(1, va, 32'hA000_0000 ^ {12'(p), 8'(o), va[11:0]}, 0, (p + o) % 3);
                access(0, va, '0, 0, 0);
                access(0, {va[31:12] ^ 20'h00003, va[11:0]}, '0, o % 3, 0);
                access(0, va, '0, p % 4, 0);
            end
        end
        // R10: ninth load replaces the first entry loaded
        load_tlb(20'h55555, 20'h0ABCD, 1);
        access(0, {vpn_of(0), 12'h010}, '0, 0, 0);
        access(1, 32'h5555_5020, 32'hCAFE_F00D, 0, 0);
        access(0, 32'h5555_5020, '0, 0, 0);
        access(0, {vpn_of(1), 12'h010}, '0, 2, 0);
        // R10: duplicate virtual page resolves to lowest entry (entry 0 holds 0x55555)
        load_tlb(20'h55555, 20'h0DDDD, 1);
        access(0, 32'h5555_5020, '0, 0, 0);
        // R1: reset clears both structures
        @(negedge clk); rst = 1; @(negedge clk); rst = 0;
        for (int i = 0; i < 8; i++) m_tv[i] = 0;
        for (int i = 0; i < 1024; i++) c_v[i] = 0;
        m_ptr = 0;
        access(0, 32'h5555_5020, '0, 0, 0);
        load_tlb(20'h55555, 20'h0ABCD, 1);
        access(0, 32'h5555_5020, '0, 3, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule